// File: doc/BRIEF.md
# DRAM refresh scheduler

This block keeps every row of a DRAM array refreshed within the retention time. An interval timer builds up refresh work. The block then raises a request to the access arbiter and holds it until the arbiter grants. Once granted, it drives the row strobe, column strobe, write enable and address lines through one complete refresh cycle. While that cycle runs, the arbiter must keep ordinary accesses away from the array.

Two strobe orderings are supported:
- **Row-address refresh.** The scheduler places the row number from its own counter on the address bus. It lowers the row strobe and keeps the column strobe high. The counter advances once the cycle ends.
- **Column-first refresh.** The scheduler lowers the column strobe one cycle before the row strobe. It keeps write enable high and drives no address, so the array's internal counter selects the row.

Two pacing styles are supported:
- **Spread.** One refresh is owed every `INTERVAL` clock cycles. The default is 3900 cycles, which is 15.6 µs at 250 MHz, so 4096 rows fit in 64 ms.
- **Bunched.** Once every `ROWS` intervals, a whole array's worth of refreshes is owed at once, and these run back to back.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `we_n` are high, and `ref_req`, `ref_busy` and `addr_oe` are low.
- R2: In spread style (`burst_mode`=0) one refresh is owed each `INTERVAL` cycles; with `ref_gnt` held high, successive row strobe falls are exactly `INTERVAL` cycles apart.
- R3: Owed refreshes are counted, never dropped: `ref_req` stays high while any is owed and `ref_gnt` is low, and no refresh starts without a grant; on grant, a backlog is issued back to back with row strobe falls `T_RAS+T_RP+2` cycles apart.
- R4: A row-address refresh (`cbr_mode`=0 at grant) holds `cas_n` high, drives `addr_oe`=1, and holds `ras_n` low for exactly `T_RAS` cycles.
- R5: A column-first refresh (`cbr_mode`=1 at grant) has `cas_n` low in the cycle before `ras_n` falls and while it is low, with `addr_oe`=0.
- R6: `we_n` is high during every refresh cycle.
- R7: The address in a row-address refresh is the internal row counter, which starts at 0, advances by one after each row-address refresh, wraps from `ROWS-1` to 0, and is unchanged by column-first refreshes.
- R8: In bunched style (`burst_mode`=1), `ROWS` refreshes become owed together once every `ROWS*INTERVAL` cycles and, with grant held, run back to back; no refresh runs between bunches.
- R9: `ref_busy` is high from the grant edge to the end of precharge, and `ref_req` is low while `ref_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cbr_mode | input | 1 | 1 selects column-first refresh, 0 row-address refresh; sampled at grant |
| burst_mode | input | 1 | 1 selects bunched pacing, 0 spread pacing |
| ref_gnt | input | 1 | Grant from the access arbiter |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_busy | output | 1 | Refresh cycle in progress; array not accessible |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low; held high during refresh |
| addr_oe | output | 1 | Address bus driven by this block |
| addr | output | ROW_W | Row address for row-address refresh |

## Verification
The bench withholds the grant across three intervals and then releases it. A design that dropped owed work would issue too few refreshes, and one that lost the queued count would space them at the interval instead of back to back. It interleaves column-first refreshes between row-address ones: a design that advanced its own counter on them would show a skipped row, and one with the wrong strobe order would show the column strobe still high just before the row strobe falls. It also runs rows past `ROWS-1`, where a bad wrap gives an out-of-range address, and it times bunched pacing so that a wrong retention count moves the second bunch away from `ROWS*INTERVAL` cycles after the first.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_PRECHG = 2'd3
    } ref_state_t;

    typedef enum logic {
        KIND_ROWADDR = 1'b0,
        KIND_COLFIRST = 1'b1
    } ref_kind_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic addr_oe;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, addr_oe: 1'b0};

    function automatic strobe_t strobes_for(ref_state_t st, ref_kind_t kind);
        strobe_t s;
        s = STROBE_QUIET;
        case (st)
            ST_SETUP: begin
                s.cas_n   = (kind == KIND_COLFIRST) ? 1'b0 : 1'b1;
                s.addr_oe = (kind == KIND_ROWADDR);
            end
            ST_ACTIVE: begin
                s.ras_n   = 1'b0;
                s.cas_n   = (kind == KIND_COLFIRST) ? 1'b0 : 1'b1;
                s.addr_oe = (kind == KIND_ROWADDR);
            end
            default: s = STROBE_QUIET;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int ROWS     = 4096,
    parameter int INTERVAL = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_mode,
    input  logic take,
    output logic pending_nz
);
    localparam int IV_W   = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int TK_W   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int PEND_W = TK_W + 2;
    localparam logic [PEND_W:0] PEND_MAX = (PEND_W+1)'((1 << PEND_W) - 1);

    logic [IV_W-1:0]   iv_cnt;
    logic [TK_W-1:0]   tk_cnt;
    logic [PEND_W-1:0] pending;
    logic              tick;
    logic              wrap;
    logic [PEND_W:0]   add;
    logic [PEND_W:0]   sum;

    assign tick = (iv_cnt == IV_W'(INTERVAL - 1));
    assign wrap = tick && (tk_cnt == TK_W'(ROWS - 1));

    always_comb begin
        if (burst_mode) add = wrap ? (PEND_W+1)'(ROWS) : '0;
        else            add = tick ? (PEND_W+1)'(1) : '0;
        sum = {1'b0, pending} + add - (PEND_W+1)'(take);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_cnt  <= '0;
            tk_cnt  <= '0;
            pending <= '0;
        end else begin
            iv_cnt <= tick ? '0 : iv_cnt + 1'b1;
            if (tick) tk_cnt <= wrap ? '0 : tk_cnt + 1'b1;
            pending <= (sum > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : sum[PEND_W-1:0];
        end
    end

    assign pending_nz = (pending != '0);

    p_take_owed_r3: assert property (@(posedge clk) disable iff (rst)
        take |-> pending_nz);

endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROWS = 4096,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    generate
        if (ROWS == (1 << ROW_W)) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst)      row <= '0;
                else if (adv) row <= row + 1'b1;
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)      row <= '0;
                else if (adv) row <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
            end
        end
    endgenerate

    p_row_in_range_r7: assert property (@(posedge clk) disable iff (rst)
        adv |=> (32'(row) < ROWS));

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import refresh_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int T_RAS = 12,
    parameter int T_RP  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cbr_mode,
    input  logic             pending_nz,
    input  logic             ref_gnt,
    input  logic [ROW_W-1:0] row,
    output logic             ref_req,
    output logic             ref_busy,
    output logic             take,
    output logic             adv,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             addr_oe,
    output logic [ROW_W-1:0] addr
);
    localparam int DLY_MAX = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int DLY_W   = $clog2(DLY_MAX) + 1;

    ref_state_t       state;
    ref_kind_t        kind;
    logic [DLY_W-1:0] dly;
    strobe_t          strb;

    assign take = (state == ST_IDLE) && pending_nz && ref_gnt;
    assign adv  = (state == ST_PRECHG) && (dly == '0) && (kind == KIND_ROWADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= KIND_ROWADDR;
            dly   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    state <= ST_SETUP;
                    kind  <= cbr_mode ? KIND_COLFIRST : KIND_ROWADDR;
                end
                ST_SETUP: begin
                    state <= ST_ACTIVE;
                    dly   <= DLY_W'(T_RAS - 1);
                end
                ST_ACTIVE: if (dly == '0) begin
                    state <= ST_PRECHG;
                    dly   <= DLY_W'(T_RP - 1);
                end else begin
                    dly <= dly - 1'b1;
                end
                ST_PRECHG: if (dly == '0) state <= ST_IDLE;
                           else           dly   <= dly - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb strb = strobes_for(state, kind);

    assign ras_n    = strb.ras_n;
    assign cas_n    = strb.cas_n;
    assign we_n     = strb.we_n;
    assign addr_oe  = strb.addr_oe;
    assign addr     = strb.addr_oe ? row : '0;
    assign ref_busy = (state != ST_IDLE);
    assign ref_req  = (state == ST_IDLE) && pending_nz;

    p_req_held_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_req && !ref_gnt) |=> ref_req);

    p_rowaddr_cas_high_r4: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && addr_oe) |-> cas_n);

    p_cas_first_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !addr_oe) |-> ($past(!cas_n) && !cas_n));

    p_we_high_r6: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> we_n);

    p_no_req_busy_r9: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> !ref_req);

    p_ras_only_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> ref_busy);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int ROWS     = 4096,
    parameter int INTERVAL = 3900,
    parameter int T_RAS    = 12,
    parameter int T_RP     = 8,
    localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cbr_mode,
    input  logic             burst_mode,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_busy,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             addr_oe,
    output logic [ROW_W-1:0] addr
);
    logic             pending_nz;
    logic             take;
    logic             adv;
    logic [ROW_W-1:0] row;

    refresh_timer #(.ROWS(ROWS), .INTERVAL(INTERVAL)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .burst_mode (burst_mode),
        .take       (take),
        .pending_nz (pending_nz)
    );

    refresh_row_ctr #(.ROWS(ROWS)) u_row (
        .clk (clk),
        .rst (rst),
        .adv (adv),
        .row (row)
    );

    refresh_seq #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cbr_mode   (cbr_mode),
        .pending_nz (pending_nz),
        .ref_gnt    (ref_gnt),
        .row        (row),
        .ref_req    (ref_req),
        .ref_busy   (ref_busy),
        .take       (take),
        .adv        (adv),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr_oe    (addr_oe),
        .addr       (addr)
    );

    p_start_granted_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_busy) |-> $past(ref_gnt && ref_req));

endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int ROWS     = 8;
    localparam int INTERVAL = 20;
    localparam int T_RAS    = 3;
    localparam int T_RP     = 2;
    localparam int GAP      = T_RAS + T_RP + 2;
    localparam int ROW_W    = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cbr_mode = 1'b0;
    logic burst_mode = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ref_busy, ras_n, cas_n, we_n, addr_oe;
    logic [ROW_W-1:0] addr;

    always #2 clk = ~clk;

    refresh_sched #(.ROWS(ROWS), .INTERVAL(INTERVAL), .T_RAS(T_RAS), .T_RP(T_RP)) uut (
        .clk(clk), .rst(rst), .cbr_mode(cbr_mode), .burst_mode(burst_mode),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_busy(ref_busy),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr_oe(addr_oe), .addr(addr)
    );

    typedef struct { bit colfirst; int row; } exp_t;
    exp_t exp_q[$];
    int   fall_log[$];
    int   checks = 0;
    int   errors = 0;
    int   model_row = 0;
    int   cyc = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_exp(input int n, input bit colfirst);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{colfirst, model_row});
            if (!colfirst) model_row = (model_row + 1) % ROWS;
        end
    endtask

    task automatic wait_empty(input int limit);
        int t = 0;
        while (exp_q.size() != 0 && t < limit) begin
            @(posedge clk); #1;
            t++;
        end
        chk(exp_q.size() == 0, "R3 expected refreshes did not all occur", exp_q.size(), 0);
    endtask

    task automatic summary_and_end();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard at every row strobe fall
    logic prev_ras = 1'b1;
    logic prev_cas = 1'b1;
    int   low_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (prev_ras && !ras_n) begin
                fall_log.push_back(cyc);
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected refresh", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.colfirst) begin
                        chk(prev_cas == 1'b0, "R5 cas_n before ras fall", int'(prev_cas), 0);
                        chk(cas_n == 1'b0, "R5 cas_n at ras fall", int'(cas_n), 0);
                        chk(addr_oe == 1'b0, "R5 addr_oe", int'(addr_oe), 0);
                    end else begin
                        chk(cas_n == 1'b1, "R4 cas_n high", int'(cas_n), 1);
                        chk(addr_oe == 1'b1, "R4 addr_oe", int'(addr_oe), 1);
                        chk(int'(addr) == e.row, "R7 row address", int'(addr), e.row);
                    end
                end
                chk(we_n == 1'b1, "R6 we_n high", int'(we_n), 1);
                chk(ref_busy && !ref_req, "R9 busy and no request", int'({ref_busy, ref_req}), 2);
            end
            if (!ras_n) begin
                low_cnt++;
                if (!cas_n) chk(!addr_oe, "R5 cas low without address", int'(addr_oe), 0);
            end else if (!prev_ras) begin
                chk(low_cnt == T_RAS, "R4 ras_n low width", low_cnt, T_RAS);
                low_cnt = 0;
            end
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 0);
        summary_and_end();
    end

    initial begin
        int n0;
        int s1;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(ras_n && cas_n && we_n, "R1 strobes high", int'({ras_n, cas_n, we_n}), 7);
        chk(!ref_req && !ref_busy && !addr_oe, "R1 req busy oe low",
            int'({ref_req, ref_busy, addr_oe}), 0);

        // R2 + R7: spread row-address refresh with grant held, rows wrap past ROWS-1
        @(posedge clk); #1;
        ref_gnt = 1'b1;
        push_exp(ROWS + 2, 1'b0);
        wait_empty(4000);
        ref_gnt = 1'b0;
        for (int i = 1; i < fall_log.size(); i++)
            chk(fall_log[i] - fall_log[i-1] == INTERVAL, "R2 spread spacing",
                fall_log[i] - fall_log[i-1], INTERVAL);

        // R3: grant withheld for three intervals
        repeat (3 * INTERVAL) @(posedge clk);
        #1;
        chk(ref_req == 1'b1, "R3 request held without grant", int'(ref_req), 1);
        chk(ref_busy == 1'b0 && ras_n == 1'b1, "R3 no refresh without grant",
            int'({ref_busy, ras_n}), 1);
        n0 = fall_log.size();
        push_exp(3, 1'b0);
        ref_gnt = 1'b1;
        wait_empty(400);
        ref_gnt = 1'b0;
        chk(fall_log.size() - n0 == 3, "R3 backlog count", fall_log.size() - n0, 3);
        for (int i = n0 + 1; i < n0 + 3; i++)
            chk(fall_log[i] - fall_log[i-1] == GAP, "R3 backlog spacing",
                fall_log[i] - fall_log[i-1], GAP);

        // R5: column-first refreshes (one queued, one on the next interval)
        cbr_mode = 1'b1;
        push_exp(2, 1'b1);
        ref_gnt = 1'b1;
        wait_empty(400);
        ref_gnt = 1'b0;

        // R7: row counter untouched by column-first refreshes
        cbr_mode = 1'b0;
        push_exp(1, 1'b0);
        ref_gnt = 1'b1;
        wait_empty(400);
        ref_gnt = 1'b0;

        // R8: bunched style
        burst_mode = 1'b1;
        push_exp(ROWS, 1'b0);
        ref_gnt = 1'b1;
        wait_empty(4 * ROWS * INTERVAL);
        s1 = fall_log.size() - ROWS;
        for (int i = s1 + 1; i < s1 + ROWS; i++)
            chk(fall_log[i] - fall_log[i-1] == GAP, "R8 bunch spacing",
                fall_log[i] - fall_log[i-1], GAP);
        push_exp(ROWS, 1'b0);
        wait_empty(4 * ROWS * INTERVAL);
        chk(fall_log[s1 + ROWS] - fall_log[s1] == ROWS * INTERVAL, "R8 bunch period",
            fall_log[s1 + ROWS] - fall_log[s1], ROWS * INTERVAL);
        ref_gnt = 1'b0;
        repeat (10) @(posedge clk);
        summary_and_end();
    end

endmodule